// File: doc/BRIEF.md
# SPI Register Word Access Sequencer

This block carries out one 32-bit register access on a controller attached over SPI. A requester presents a direction, a 16-bit register address and, for writes, a 32-bit data word. The sequencer lowers chip select, sends a fixed series of bytes through an internal byte shifter, and raises chip select again. It then reports the result with a one-cycle completion strobe, together with an error flag and, for reads, the assembled data word.

Every access begins with a command byte and the address, high byte first. On a write the data word follows, lowest byte first. On a read one dummy byte follows the address, then four bytes are clocked in while zeros are driven out, and the first of those four bytes becomes the least significant byte of the result. Each byte exchange is timed. When one runs too long, the access is abandoned, chip select is released, and the error flag is set. Addresses at or above the valid limit are refused before any bus activity.

Top module: `spi_word_seq`

## Requirements
- R1: A write is framed as command 0x02, address bits [15:8], address bits [7:0], then the data bytes [7:0], [15:8], [23:16], [31:24], for seven bytes under one chip-select low period.
- R2: A read is framed as command 0x0B, address bits [15:8], address bits [7:0], one dummy byte, then four receive bytes. The dummy byte and the four receive bytes are all transmitted as 0x00, for eight bytes under one chip-select low period.
- R3: For a read, the first byte received after the dummy byte lands in rd_data[7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24]. rd_data is valid while done is high.
- R4: A request whose address is 0x400 or above is refused. done and err are high on the cycle after acceptance, and chip select never goes low.
- R5: When a byte exchange does not complete within TIMEOUT_CYC cycles, the access stops, chip select returns high, and done is raised with err = 1.
- R6: busy is high whenever chip select is low. spi_sclk is low whenever chip select is high.
- R7: A request presented while busy is high is ignored: it produces no bus activity and no completion.
- R8: done is a single-cycle pulse that marks the last busy cycle. A successful access reports err = 0, and a write reports rd_data = 0.
- R9: After reset, spi_cs_n = 1, spi_sclk = 0, busy = 0 and done = 0.
- R10: The serial clock idles low. Each byte is sent most significant bit first on spi_mosi, which is stable around each rising edge, and spi_miso is sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | Register address |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 32 | Assembled read data |
| err | output | 1 | Access failed (refused address or timeout) |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A refused address has a fixed latency, so the bench samples done and err at the falling clock edge exactly one cycle after the accepting edge. Bytes on the wire have no fixed cycle position that is worth predicting. Instead, each byte is decoded by a slave model at its eighth rising serial-clock edge and compared at that moment against the next entry in the expected-byte queue. The result of a full access is compared on whichever cycle done is high. The timeout instance must raise done within a small bound after its single request. Requests issued while busy must leave both the byte queue and the chip-select fall count unchanged.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;

    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 32;
    localparam int BYTE_W      = 8;
    localparam int DATA_BYTES  = DATA_W / BYTE_W;
    localparam int LANE_W      = $clog2(DATA_BYTES);
    localparam int IDX_W       = 3;

    localparam logic [BYTE_W-1:0] CMD_WR = 8'h02;
    localparam logic [BYTE_W-1:0] CMD_RD = 8'h0B;

    // index of the first received data byte in a read frame
    localparam logic [IDX_W-1:0] RD_DATA_IDX = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RELEASE,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic              is_write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } word_req_t;

    function automatic logic [IDX_W-1:0] last_index(input logic is_write);
        return is_write ? 3'd6 : 3'd7;
    endfunction

    function automatic logic [BYTE_W-1:0] frame_byte(input word_req_t r,
                                                     input logic [IDX_W-1:0] idx);
        logic [DATA_W-1:0] shifted;
        logic [IDX_W-1:0]  lane;
        lane    = idx - 3'd3;
        shifted = r.wdata >> {lane, 3'b000};
        case (idx)
            3'd0:    return r.is_write ? CMD_WR : CMD_RD;
            3'd1:    return r.addr[15:8];
            3'd2:    return r.addr[7:0];
            default: return r.is_write ? shifted[BYTE_W-1:0] : 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int CLK_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       abort,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

    logic          active_q;
    logic          sclk_q;
    logic [7:0]    tx_q;
    logic [7:0]    rx_q;
    logic [2:0]    bit_q;
    logic [DW-1:0] div_q;
    logic          ov_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            tx_q     <= '0;
            rx_q     <= '0;
            bit_q    <= '0;
            div_q    <= '0;
            ov_q     <= 1'b0;
        end else begin
            ov_q <= 1'b0;
            if (abort) begin
                active_q <= 1'b0;
                sclk_q   <= 1'b0;
            end else if (!active_q) begin
                if (in_valid) begin
                    active_q <= 1'b1;
                    tx_q     <= in_byte;
                    bit_q    <= '0;
                    div_q    <= '0;
                    sclk_q   <= 1'b0;
                end
            end else if (div_q == DIV_LAST) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    tx_q   <= {tx_q[6:0], 1'b0};
                    if (bit_q == 3'd7) begin
                        active_q <= 1'b0;
                        ov_q     <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                    end
                end
            end else begin
                div_q <= div_q + DW'(1);
            end
        end
    end

    assign in_ready  = !active_q;
    assign out_valid = ov_q;
    assign out_byte  = rx_q;
    assign sclk      = sclk_q;
    assign mosi      = active_q ? tx_q[7] : 1'b0;

endmodule

// File: rtl/spi_byte_timer.sv
module spi_byte_timer #(
    parameter int TIMEOUT_CYC = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expired = run && (cnt_q >= LIMIT);

endmodule

// File: rtl/spi_rdata_pack.sv
module spi_rdata_pack
    import spi_word_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              cap_en,
    input  logic [LANE_W-1:0] cap_lane,
    input  logic [BYTE_W-1:0] cap_byte,
    output logic [DATA_W-1:0] word
);
    logic [DATA_BYTES-1:0][BYTE_W-1:0] lanes_q;

    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                lanes_q[g] <= '0;
            end else if (cap_en && (cap_lane == LANE_W'(g))) begin
                lanes_q[g] <= cap_byte;
            end
        end
    end

    assign word = lanes_q;

endmodule

// File: rtl/spi_word_fsm.sv
module spi_word_fsm
    import spi_word_pkg::*;
#(
    parameter int unsigned ADDR_LIMIT = 32'h400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  word_req_t         req,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              cs_n,
    output logic              sh_in_valid,
    output logic [BYTE_W-1:0] sh_in_byte,
    input  logic              sh_out_valid,
    output logic              sh_abort,
    output logic              tmr_start,
    output logic              tmr_run,
    input  logic              tmr_expired,
    output logic              cap_clear,
    output logic              cap_en,
    output logic [LANE_W-1:0] cap_lane
);
    seq_state_e       state_q;
    word_req_t        req_q;
    logic [IDX_W-1:0] idx_q;
    logic             err_q;
    logic             cs_n_q;
    logic             accept;
    logic             in_range;

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign in_range = 32'(req.addr) < ADDR_LIMIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
            idx_q   <= '0;
            err_q   <= 1'b0;
            cs_n_q  <= 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q <= req;
                        idx_q <= '0;
                        if (in_range) begin
                            err_q   <= 1'b0;
                            cs_n_q  <= 1'b0;
                            state_q <= ST_SEND;
                        end else begin
                            err_q   <= 1'b1;
                            state_q <= ST_FINISH;
                        end
                    end
                end
                ST_SEND: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (sh_out_valid) begin
                        if (idx_q == last_index(req_q.is_write)) begin
                            cs_n_q  <= 1'b1;
                            state_q <= ST_RELEASE;
                        end else begin
                            idx_q   <= idx_q + 3'd1;
                            state_q <= ST_SEND;
                        end
                    end else if (tmr_expired) begin
                        err_q   <= 1'b1;
                        cs_n_q  <= 1'b1;
                        state_q <= ST_RELEASE;
                    end
                end
                ST_RELEASE: state_q <= ST_FINISH;
                ST_FINISH:  state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign done        = (state_q == ST_FINISH);
    assign err         = err_q;
    assign cs_n        = cs_n_q;
    assign sh_in_valid = (state_q == ST_SEND);
    assign sh_in_byte  = frame_byte(req_q, idx_q);
    assign sh_abort    = (state_q == ST_WAIT) && !sh_out_valid && tmr_expired;
    assign tmr_start   = (state_q == ST_SEND);
    assign tmr_run     = (state_q == ST_WAIT);
    assign cap_clear   = accept;
    assign cap_en      = (state_q == ST_WAIT) && sh_out_valid && !req_q.is_write
                         && (idx_q >= RD_DATA_IDX);
    assign cap_lane    = idx_q[LANE_W-1:0];

endmodule

// File: rtl/spi_word_seq.sv
module spi_word_seq
    import spi_word_pkg::*;
#(
    parameter int          CLK_DIV     = 2,
    parameter int          TIMEOUT_CYC = 1024,
    parameter int unsigned ADDR_LIMIT  = 32'h400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              err,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    word_req_t         req;
    logic              sh_in_valid;
    logic [BYTE_W-1:0] sh_in_byte;
    logic              sh_in_ready;
    logic              sh_out_valid;
    logic [BYTE_W-1:0] sh_out_byte;
    logic              sh_abort;
    logic              tmr_start;
    logic              tmr_run;
    logic              tmr_expired;
    logic              cap_clear;
    logic              cap_en;
    logic [LANE_W-1:0] cap_lane;

    assign req = '{is_write: req_write, addr: req_addr, wdata: req_wdata};

    spi_word_fsm #(.ADDR_LIMIT(ADDR_LIMIT)) u_fsm (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req(req),
        .busy(busy), .done(done), .err(err), .cs_n(spi_cs_n),
        .sh_in_valid(sh_in_valid), .sh_in_byte(sh_in_byte),
        .sh_out_valid(sh_out_valid), .sh_abort(sh_abort),
        .tmr_start(tmr_start), .tmr_run(tmr_run), .tmr_expired(tmr_expired),
        .cap_clear(cap_clear), .cap_en(cap_en), .cap_lane(cap_lane)
    );

    spi_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst(rst), .abort(sh_abort),
        .in_valid(sh_in_valid), .in_byte(sh_in_byte), .in_ready(sh_in_ready),
        .out_valid(sh_out_valid), .out_byte(sh_out_byte),
        .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
    );

    spi_byte_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst(rst), .start(tmr_start), .run(tmr_run),
        .expired(tmr_expired)
    );

    spi_rdata_pack u_pack (
        .clk(clk), .rst(rst), .clear(cap_clear),
        .cap_en(cap_en), .cap_lane(cap_lane), .cap_byte(sh_out_byte),
        .word(rd_data)
    );

endmodule

// File: rtl/spi_word_seq_chk.sv
module spi_word_seq_chk #(
    parameter int unsigned ADDR_LIMIT = 32'h400
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [15:0] req_addr,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        spi_cs_n,
    input logic        spi_sclk
);
    AST_CS_LOW_BUSY: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> busy); // R6

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        done |-> spi_cs_n); // R5

    AST_REFUSE_ADDR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && (32'(req_addr) >= ADDR_LIMIT)) |=> (done && err)); // R4

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy); // R7

endmodule

bind spi_word_seq spi_word_seq_chk #(.ADDR_LIMIT(ADDR_LIMIT)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .done(done), .err(err),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk)
);

// File: tb/spi_word_seq_tb.sv
module spi_word_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, done, err, spi_cs_n, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;
    logic [31:0] rd_data;

    logic        t_valid = 1'b0;
    logic        t_busy, t_done, t_err, t_cs_n, t_sclk, t_mosi;
    logic [31:0] t_rd;

    always #5 clk = !clk;

    spi_word_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .err(err), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    spi_word_seq #(.TIMEOUT_CYC(8)) u_dut_to (
        .clk(clk), .rst(rst), .req_valid(t_valid), .req_write(1'b1),
        .req_addr(16'h0010), .req_wdata(32'h1234_5678), .busy(t_busy), .done(t_done),
        .rd_data(t_rd), .err(t_err), .spi_cs_n(t_cs_n), .spi_sclk(t_sclk),
        .spi_mosi(t_mosi), .spi_miso(1'b0)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cs_falls = 0;
    int done_cnt = 0;
    int cs_busy_bad = 0;
    bit finished = 1'b0;

    logic [7:0]  exp_byte[$];
    string       exp_btag[$];
    logic        exp_err[$];
    logic [31:0] exp_rd[$];
    string       exp_rtag[$];

    logic [63:0] miso_stream = '0;
    int          bitcnt = 0;
    logic [7:0]  sh_in = '0;

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // slave model: R10 mode-0 wire format
    always @(negedge spi_cs_n) begin
        cs_falls++;
        bitcnt = 0;
        spi_miso = miso_stream[63];
    end

    always @(posedge spi_sclk) begin
        sh_in = {sh_in[6:0], spi_mosi};
        bitcnt++;
        if (bitcnt % 8 == 0) begin
            if (exp_byte.size() == 0) begin
                chk(1'b0, "R7 unexpected byte", 64'(sh_in), 64'h0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_byte.pop_front();
                t = exp_btag.pop_front();
                chk(sh_in == e, t, 64'(sh_in), 64'(e));
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (bitcnt < 64) spi_miso = miso_stream[63 - bitcnt];
    end

    // result monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (!spi_cs_n && !busy) cs_busy_bad++;
            if (done) begin
                done_cnt++;
                if (exp_err.size() == 0) begin
                    chk(1'b0, "R7 unexpected done", 64'(done), 64'h0);
                end else begin
                    logic        ee;
                    logic [31:0] er;
                    string       t;
                    ee = exp_err.pop_front();
                    er = exp_rd.pop_front();
                    t  = exp_rtag.pop_front();
                    chk(err == ee, {t, " err"}, 64'(err), 64'(ee));
                    chk(rd_data == er, {t, " rd_data"}, 64'(rd_data), 64'(er));
                end
            end
        end
    end

    task automatic push_b(input logic [7:0] b, input string t);
        exp_byte.push_back(b);
        exp_btag.push_back(t);
    endtask

    task automatic expect_access(input logic wr, input logic [15:0] a,
                                 input logic [31:0] d, input logic [31:0] ret);
        if (wr) begin
            push_b(8'h02, "R1 cmd");
            push_b(a[15:8], "R1 addr hi");
            push_b(a[7:0], "R1 addr lo");
            for (int i = 0; i < 4; i++) push_b(d[8*i +: 8], "R1 data byte");
            miso_stream = {64{1'b1}};
            exp_rd.push_back(32'h0);
            exp_rtag.push_back("R8 write result");
        end else begin
            push_b(8'h0B, "R2 cmd");
            push_b(a[15:8], "R2 addr hi");
            push_b(a[7:0], "R2 addr lo");
            for (int i = 0; i < 5; i++) push_b(8'h00, "R2 dummy/rx filler");
            miso_stream = {32'hA5A5A5A5, ret[7:0], ret[15:8], ret[23:16], ret[31:24]};
            exp_rd.push_back(ret);
            exp_rtag.push_back("R3 read result");
        end
        exp_err.push_back(1'b0);
    endtask

    task automatic drive(input logic wr, input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic access(input logic wr, input logic [15:0] a,
                          input logic [31:0] d, input logic [31:0] ret);
        expect_access(wr, a, d, ret);
        drive(wr, a, d);
        wait_done();
    endtask

    task automatic refuse(input logic wr, input logic [15:0] a);
        int falls0;
        falls0 = cs_falls;
        exp_err.push_back(1'b1);
        exp_rd.push_back(32'h0);
        exp_rtag.push_back("R4 refused");
        drive(wr, a, 32'hDEAD_BEEF);
        chk(done && err, "R4 done+err one cycle after accept", 64'({done, err}), 64'h3);
        @(negedge clk);
        chk(cs_falls == falls0, "R4 no chip select", 64'(cs_falls), 64'(falls0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(spi_cs_n && !spi_sclk && !busy && !done, "R9 reset state",
            64'({spi_cs_n, spi_sclk, busy, done}), 64'b1000);

        access(1'b1, 16'h0123, 32'hA1B2_C3D4, 32'h0);
        access(1'b0, 16'h03FF, 32'h0, 32'h8765_4321);
        access(1'b1, 16'h0000, 32'hFFFF_FFFF, 32'h0);
        access(1'b0, 16'h0064, 32'h0, 32'h0000_0001);
        refuse(1'b1, 16'h0400);
        refuse(1'b0, 16'hFFFF);
        access(1'b0, 16'h03FF, 32'h0, 32'h8765_4321);

        // R7: requests while busy are ignored
        begin
            int falls0, dn0;
            falls0 = cs_falls;
            dn0 = done_cnt;
            expect_access(1'b0, 16'h0201, 32'h0, 32'hC0FF_EE11);
            drive(1'b0, 16'h0201, 32'h0);
            repeat (4) @(negedge clk);
            req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0033; req_wdata = 32'h5555_AAAA;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
            wait_done();
            repeat (5) @(negedge clk);
            chk(cs_falls == falls0 + 1, "R7 one frame only", 64'(cs_falls), 64'(falls0 + 1));
            chk(done_cnt == dn0 + 1, "R7 one completion only", 64'(done_cnt), 64'(dn0 + 1));
        end

        // R5: timeout on the short-timeout instance
        begin
            int n;
            @(negedge clk);
            t_valid = 1'b1;
            @(negedge clk);
            t_valid = 1'b0;
            n = 0;
            while (!t_done && n < 100) begin @(negedge clk); n++; end
            chk(t_done && t_err, "R5 timeout error", 64'({t_done, t_err}), 64'h3);
            chk(t_cs_n && !t_sclk, "R5 bus released", 64'({t_cs_n, t_sclk}), 64'b10);
            chk(n < 40, "R5 abort bound", 64'(n), 64'd40);
            @(negedge clk);
            chk(!t_busy && !t_done, "R8 timeout done single", 64'({t_busy, t_done}), 64'h0);
        end

        chk(exp_byte.size() == 0, "R1 R2 all bytes seen", 64'(exp_byte.size()), 64'h0);
        chk(exp_err.size() == 0, "R8 all results seen", 64'(exp_err.size()), 64'h0);
        chk(cs_busy_bad == 0, "R6 busy covers chip select", 64'(cs_busy_bad), 64'h0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(150000 * 10);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule